// File: doc/BRIEF.md
# Padded Vertex Count Calculator

A thread dispatcher that turns one linear index into a (vertex, instance) pair must divide by the per-instance vertex count. Division by an arbitrary number is costly. This block rounds the vertex count up to a padded count that is cheap to divide, because it is always 1, 3, 5, 7 or 9 times a power of two. Only the leading bits of the count decide which form is used. Compared with padding to the next power of two, fewer padding threads are wasted.

The block takes one unsigned count per valid strobe. One cycle later it presents three results: the padded count, the power-of-two exponent, and a 3-bit odd-factor code m, where padded = (2m+1) << shift. Counts below 20 are handled by a fixed bucket table. From 20 upward, the block finds the most significant set bit and uses the three bits below it to select one of five forms.

Top module: `padded_vertex_calc`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, so the latency is one clock.
- R2: While `rst` is high, all outputs are driven to zero.
- R3: The padded count is always strictly greater than the input count.
- R4: The padded count is always a multiple of four.
- R5: Counts 0 to 19 map by groups of four: 0–3→4, 4–7→8, 8–11→12, 12–15→16, 16–19→20.
- R6: For counts of 20 or more, let p be the position of the most significant set bit and n = p−3. Let t = count >> n, which lies in 8..15. Then t=8 gives 9<<n, t=9 gives 10<<n, t=10 or 11 gives 12<<n, t=12 or 13 gives 14<<n, and t=14 or 15 gives 16<<n.
- R7: `out_shift` is the number of trailing zeros of the padded count. The odd part of the padded count equals 2·`out_odd`+1, so `out_odd` is 0, 1, 2, 3 or 4 for the odd factors 1, 3, 5, 7 and 9.
- R8: A count of 70 yields a padded count of 72, with shift 3 and odd code 4.
- R9: While `in_valid` is low, the count, shift and odd-code outputs hold their last values, whatever `in_count` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe qualifying `in_count` |
| in_count | input | 32 | Vertex count, below 2^31 |
| out_valid | output | 1 | Results are new this cycle |
| out_padded | output | 32 | Padded vertex count |
| out_shift | output | 5 | Power-of-two exponent of the padded count |
| out_odd | output | 3 | Odd-factor code m, where the odd factor is 2m+1 |

## Verification
The assertions assume that every strobed count has its top bit clear. Above 2^31 the largest padded form would not fit in 32 bits, and the checks on ordering and encoding would no longer apply. One assertion states this assumption on the input. The stimulus keeps within it: an exhaustive sweep of 0 to 4096, then powers of two, values just below and just above them, and mid-range patterns, all of them topping out at 2^31−1.

// File: rtl/pad_pkg.sv
package pad_pkg;
  // odd-factor codes, where the odd factor is 2*code+1
  localparam int ODD_W    = 3;
  localparam logic [ODD_W-1:0] ODD_X1 = 3'd0;
  localparam logic [ODD_W-1:0] ODD_X3 = 3'd1;
  localparam logic [ODD_W-1:0] ODD_X5 = 3'd2;
  localparam logic [ODD_W-1:0] ODD_X7 = 3'd3;
  localparam logic [ODD_W-1:0] ODD_X9 = 3'd4;
  // counts below this use the bucket table
  localparam int SMALL_LIMIT = 20;
  // bucket index width for counts below SMALL_LIMIT (count >> 2)
  localparam int BUCKET_W = 3;
endpackage

// File: rtl/lead_one_pos.sv
module lead_one_pos #(
  parameter int W     = 32,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = POS_W'(i);
    end
  end
endmodule

// File: rtl/small_pad_lut.sv
module small_pad_lut #(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = $clog2(CNT_W)
) (
  input  logic [pad_pkg::BUCKET_W-1:0] bucket,
  output logic [CNT_W-1:0]             padded,
  output logic [SHIFT_W-1:0]           shift,
  output logic [pad_pkg::ODD_W-1:0]    odd
);
  import pad_pkg::*;
  always_comb begin
    padded = CNT_W'((32'(bucket) + 32'd1) << 2);
    unique case (bucket)
      3'd0:    begin shift = SHIFT_W'(2); odd = ODD_X1; end
      3'd1:    begin shift = SHIFT_W'(3); odd = ODD_X1; end
      3'd2:    begin shift = SHIFT_W'(2); odd = ODD_X3; end
      3'd3:    begin shift = SHIFT_W'(4); odd = ODD_X1; end
      default: begin shift = SHIFT_W'(2); odd = ODD_X5; end
    endcase
  end
endmodule

// File: rtl/lead_pattern_pad.sv
module lead_pattern_pad #(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = $clog2(CNT_W)
) (
  input  logic [CNT_W-1:0]          count,
  input  logic [SHIFT_W-1:0]        msb_pos,
  output logic [CNT_W-1:0]          padded,
  output logic [SHIFT_W-1:0]        shift,
  output logic [pad_pkg::ODD_W-1:0] odd
);
  import pad_pkg::*;
  logic [SHIFT_W-1:0] n;
  logic [2:0]         follow;

  always_comb begin
    follow = 3'b000;
    n      = '0;
    if (msb_pos >= SHIFT_W'(3)) begin
      n      = msb_pos - SHIFT_W'(3);
      follow = {count[msb_pos - SHIFT_W'(1)],
                count[msb_pos - SHIFT_W'(2)],
                count[msb_pos - SHIFT_W'(3)]};
    end
  end

  always_comb begin
    casez (follow)
      3'b000: begin
        odd = ODD_X9; shift = n;
        padded = CNT_W'(9) << n;
      end
      3'b001: begin
        odd = ODD_X5; shift = n + SHIFT_W'(1);
        padded = CNT_W'(5) << (n + SHIFT_W'(1));
      end
      3'b01?: begin
        odd = ODD_X3; shift = n + SHIFT_W'(2);
        padded = CNT_W'(3) << (n + SHIFT_W'(2));
      end
      3'b10?: begin
        odd = ODD_X7; shift = n + SHIFT_W'(1);
        padded = CNT_W'(7) << (n + SHIFT_W'(1));
      end
      default: begin
        odd = ODD_X1; shift = n + SHIFT_W'(4);
        padded = CNT_W'(1) << (n + SHIFT_W'(4));
      end
    endcase
  end
endmodule

// File: rtl/padded_vertex_calc.sv
module padded_vertex_calc #(
  parameter int CNT_W   = 32,
  parameter int SHIFT_W = $clog2(CNT_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [CNT_W-1:0]          in_count,
  output logic                      out_valid,
  output logic [CNT_W-1:0]          out_padded,
  output logic [SHIFT_W-1:0]        out_shift,
  output logic [pad_pkg::ODD_W-1:0] out_odd
);
  import pad_pkg::*;

  logic [SHIFT_W-1:0]  msb_pos;
  logic [CNT_W-1:0]    sm_padded, lg_padded, nx_padded;
  logic [SHIFT_W-1:0]  sm_shift, lg_shift, nx_shift;
  logic [ODD_W-1:0]    sm_odd, lg_odd, nx_odd;
  logic                is_small;

  lead_one_pos #(.W(CNT_W), .POS_W(SHIFT_W)) lead_i (
    .vec(in_count), .pos(msb_pos)
  );

  small_pad_lut #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) lut_i (
    .bucket(in_count[BUCKET_W+1:2]),
    .padded(sm_padded), .shift(sm_shift), .odd(sm_odd)
  );

  lead_pattern_pad #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) pat_i (
    .count(in_count), .msb_pos(msb_pos),
    .padded(lg_padded), .shift(lg_shift), .odd(lg_odd)
  );

  assign is_small = in_count < CNT_W'(SMALL_LIMIT);

  always_comb begin
    if (is_small) begin
      nx_padded = sm_padded; nx_shift = sm_shift; nx_odd = sm_odd;
    end else begin
      nx_padded = lg_padded; nx_shift = lg_shift; nx_odd = lg_odd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_padded <= '0;
      out_shift  <= '0;
      out_odd    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_padded <= nx_padded;
        out_shift  <= nx_shift;
        out_odd    <= nx_odd;
      end
    end
  end

  // input precondition: strobed counts stay below 2^(CNT_W-1)
  input_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !in_count[CNT_W-1]);

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  // R3
  pad_above_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_padded > $past(in_count));

  // R4
  quad_align_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_padded[1:0] == 2'b00);

  // R7
  encode_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_padded == (CNT_W'(2 * out_odd + 1) << out_shift));

  // R7
  odd_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_odd <= ODD_X9);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> ($stable(out_padded) && $stable(out_shift) && $stable(out_odd)));
endmodule

// File: tb/padded_vertex_calc_tb_top.sv
module padded_vertex_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_count = '0;
  logic        out_valid;
  logic [31:0] out_padded;
  logic [4:0]  out_shift;
  logic [2:0]  out_odd;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  padded_vertex_calc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_count(in_count),
    .out_valid(out_valid), .out_padded(out_padded),
    .out_shift(out_shift), .out_odd(out_odd)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input logic [31:0] stim);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s count=%0d actual=%0d expected=%0d", req, stim, act, exp);
    end
  endtask

  // reference: small buckets (R5), leading-pattern table (R6)
  function automatic logic [31:0] ref_pad(input logic [31:0] c);
    int p = 0;
    int n;
    logic [31:0] t;
    if (c < 20) return ((c >> 2) + 1) << 2;
    for (int i = 0; i < 32; i++) if (c[i]) p = i;
    n = p - 3;
    t = c >> n;
    if (t == 8)       return 32'd9  << n;
    else if (t == 9)  return 32'd10 << n;
    else if (t < 12)  return 32'd12 << n;
    else if (t < 14)  return 32'd14 << n;
    else              return 32'd16 << n;
  endfunction

  function automatic int ref_tz(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic apply(input logic [31:0] c);
    logic [31:0] ep;
    int tz;
    @(negedge clk);
    in_count = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ep = ref_pad(c);
    tz = ref_tz(ep);
    chk("R1 valid", 32'(out_valid), 32'd1, c);
    chk("R5/R6 padded", out_padded, ep, c);
    chk("R7 shift", 32'(out_shift), 32'(tz), c);
    chk("R7 odd", 32'(out_odd), ((ep >> tz) - 1) / 2, c);
    checks++;
    if (!(out_padded > c) || out_padded[1:0] != 2'b00) begin
      fails++;
      $display("FAIL R3/R4 count=%0d actual=%0d expected=above and multiple of 4",
               c, out_padded);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R2 reset state
    chk("R2 valid", 32'(out_valid), 32'd0, 0);
    chk("R2 padded", out_padded, 32'd0, 0);
    chk("R2 shift", 32'(out_shift), 32'd0, 0);
    chk("R2 odd", 32'(out_odd), 32'd0, 0);
    rst = 1'b0;
    // R8 worked example
    apply(32'd70);
    chk("R8 padded", out_padded, 32'd72, 70);
    chk("R8 shift", 32'(out_shift), 32'd3, 70);
    chk("R8 odd", 32'(out_odd), 32'd4, 70);
    // R9 hold while idle
    @(negedge clk);
    in_count = 32'd5000;
    @(negedge clk);
    chk("R9 valid low", 32'(out_valid), 32'd0, 5000);
    chk("R9 padded held", out_padded, 32'd72, 5000);
    chk("R9 shift held", 32'(out_shift), 32'd3, 5000);
    chk("R9 odd held", 32'(out_odd), 32'd4, 5000);
    // R5 and R6 exhaustive low range
    for (int c = 0; c <= 4096; c++) apply(32'(c));
    // R6 wide range corners
    for (int k = 5; k < 31; k++) begin
      apply(32'd1 << k);
      apply((32'd1 << k) - 1);
      apply((32'd1 << k) + 1);
      apply((32'd9 << (k - 3)));
      apply((32'd9 << (k - 3)) - 1);
      apply((32'd11 << (k - 4)) | 32'd1);
      apply((32'd13 << (k - 4)));
    end
    apply(32'h7FFF_FFFF);
    chk("R6 top", out_padded, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(32'h4000_0000);
    chk("R6 1000", out_padded, 32'h4800_0000, 32'h4000_0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule